// File: doc/BRIEF.md
# Dual-Group Thread Picker with Shared-Unit Conflict Resolution

This block chooses which hardware threads of a core send an instruction toward execution each cycle. Eight threads are split into two fixed groups of four. Each group runs its own least-recently-picked arbiter and selects at most one ready thread per cycle, without regard to what the other group chose. A picked instruction moves into a one-entry decode slot for its group.

The decode stage compares the classes of the two instructions it holds. The core has one load/store unit and one floating-point unit, so when both slots hold instructions for the same one of those units, only one may leave. The other is held in its slot and tried again on the next cycle. The group that wins such a conflict alternates from one conflict to the next. A group that is holding an instruction does not pick. A thread moves to the back of its group's priority order only when its instruction leaves decode.

Top module: `dual_group_picker`

## Requirements
- R1: Threads 0..3 form group 0 and threads 4..7 form group 1. A group's pick valid is high only for a thread of that group whose ready flag is set, and at most one thread is picked per group per cycle.
- R2: Within a group, the picked thread is the ready thread whose instruction left decode least recently. After reset the order is ascending thread number, with the lowest number first.
- R3: A thread's place in the order changes only in the cycle its instruction issues from decode. Being picked, or being held in decode, does not move it.
- R4: A group with no ready thread has pick valid low, and its priority order is left unchanged.
- R5: The two groups pick in the same cycle, and neither pick depends on the other group's ready flags or classes.
- R6: Each thread supplies a 2-bit class at `cls_i[2t+1:2t]`. 2'b01 is load/store, 2'b10 is floating point, and 2'b00 and 2'b11 use no shared unit. A conflict exists when both decode slots are valid and hold the same class, and that class is 2'b01 or 2'b10.
- R7: On a conflict, exactly one group issues and the other is stalled. The group that wins alternates on each conflict, and group 0 wins the first conflict after reset.
- R8: A stalled group's pick valid is low. On the next cycle, the same thread is still in its decode slot, and it either issues or stalls again.
- R9: A pick enters decode on the next clock edge. Without a conflict, every valid decode slot issues in that cycle.
- R10: An asynchronous active-low reset empties both decode slots, restores the ascending priority order in both groups, and gives group 0 priority for the next conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 8 | Per-thread ready flag |
| cls_i | input | 16 | Per-thread 2-bit class of the head instruction |
| pick_vld_o | output | 2 | Per-group pick valid |
| pick_tid_o | output | 6 | Per-group picked thread number, 3 bits each, group 0 in the low bits |
| dec_tid_o | output | 6 | Per-group thread number held in decode, 3 bits each |
| issue_o | output | 2 | Per-group instruction leaves decode this cycle |
| stall_o | output | 2 | Per-group instruction is held in decode this cycle |

## Verification
The bench drives runs in which both groups hit the load/store unit, and then the floating-point unit, on consecutive cycles. A resolver that does not alternate would starve one group, and one that resolves ties at pick time would show a stalled group that still picks. Other sequences let a thread be picked and then held before it issues, so a priority update made at pick time instead of at issue would pick a different thread. A load/store instruction paired with a floating-point instruction, and class 2'b11 instructions, are used to catch a design that flags a conflict on any pair of unit-using classes. A reset in the middle of a run, applied after a conflict, shows whether the winner priority and the thread order both return to their start values.

// File: rtl/dgp_pkg.sv
package dgp_pkg;
  typedef enum logic [1:0] {
    CLS_ALU = 2'b00,
    CLS_LSU = 2'b01,
    CLS_FPU = 2'b10,
    CLS_CTL = 2'b11
  } cls_e;

  function automatic logic uses_shared(cls_e c);
    return (c == CLS_LSU) || (c == CLS_FPU);
  endfunction
endpackage

// File: rtl/dgp_lrp_arb.sv
module dgp_lrp_arb #(
  parameter int N   = 4,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   req_i,
  input  logic           upd_vld_i,
  input  logic [IDW-1:0] upd_idx_i,
  output logic           gnt_vld_o,
  output logic [IDW-1:0] gnt_idx_o
);
  // pri_q[i][j] set: entry i is ahead of entry j
  logic [N-1:0][N-1:0] pri_q;
  logic [N-1:0]        win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          pri_q[i][j] <= (i < j);
    end else if (upd_vld_i) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (i != j) begin
            if (upd_idx_i == IDW'(i))      pri_q[i][j] <= 1'b0;
            else if (upd_idx_i == IDW'(j)) pri_q[i][j] <= 1'b1;
          end
    end
  end

  always_comb begin
    win = '0;
    for (int i = 0; i < N; i++) begin
      win[i] = req_i[i];
      for (int j = 0; j < N; j++)
        if (j != i && req_i[j] && !pri_q[i][j]) win[i] = 1'b0;
    end
  end

  always_comb begin
    gnt_idx_o = '0;
    for (int i = 0; i < N; i++)
      if (win[i]) gnt_idx_o = IDW'(i);
  end

  assign gnt_vld_o = |req_i;
endmodule

// File: rtl/dgp_resolver.sv
module dgp_resolver
  import dgp_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     dec_vld_i,
  input  cls_e [1:0]     dec_cls_i,
  output logic [1:0]     issue_o,
  output logic [1:0]     stall_o
);
  logic prio_q;  // 0: group 0 wins next conflict
  logic clash;

  assign clash = dec_vld_i[0] && dec_vld_i[1] && uses_shared(dec_cls_i[0])
               && (dec_cls_i[0] == dec_cls_i[1]);

  assign stall_o[0] = clash && prio_q;
  assign stall_o[1] = clash && !prio_q;
  assign issue_o    = dec_vld_i & ~stall_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prio_q <= 1'b0;
    else if (clash) prio_q <= ~prio_q;
  end
endmodule

// File: rtl/dual_group_picker.sv
module dual_group_picker
  import dgp_pkg::*;
#(
  parameter int THREADS = 8,
  parameter int CLS_W   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [THREADS-1:0]            ready_i,
  input  logic [THREADS*CLS_W-1:0]      cls_i,
  output logic [1:0]                    pick_vld_o,
  output logic [2*$clog2(THREADS)-1:0]  pick_tid_o,
  output logic [2*$clog2(THREADS)-1:0]  dec_tid_o,
  output logic [1:0]                    issue_o,
  output logic [1:0]                    stall_o
);
  localparam int GROUPS  = 2;
  localparam int PER_GRP = THREADS / GROUPS;
  localparam int LIDW    = (PER_GRP > 1) ? $clog2(PER_GRP) : 1;
  localparam int TIDW    = $clog2(THREADS);

  logic [GROUPS-1:0] dec_vld_q;
  cls_e [GROUPS-1:0] dec_cls_q;
  logic [LIDW-1:0]   dec_lidx_q [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [PER_GRP-1:0] req;
    logic               gnt_vld;
    logic [LIDW-1:0]    gnt_idx;
    logic [CLS_W-1:0]   gnt_cls;

    // a holding group does not pick
    assign req = ready_i[g*PER_GRP +: PER_GRP] & {PER_GRP{~stall_o[g]}};

    dgp_lrp_arb #(.N(PER_GRP), .IDW(LIDW)) u_arb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req),
      .upd_vld_i (issue_o[g]),
      .upd_idx_i (dec_lidx_q[g]),
      .gnt_vld_o (gnt_vld),
      .gnt_idx_o (gnt_idx)
    );

    assign gnt_cls = cls_i[(g*PER_GRP + int'(gnt_idx))*CLS_W +: CLS_W];
    assign pick_vld_o[g] = gnt_vld;
    assign pick_tid_o[g*TIDW +: TIDW] = TIDW'(g*PER_GRP) + TIDW'(gnt_idx);
    assign dec_tid_o[g*TIDW +: TIDW]  = TIDW'(g*PER_GRP) + TIDW'(dec_lidx_q[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dec_vld_q[g]  <= 1'b0;
        dec_lidx_q[g] <= '0;
        dec_cls_q[g]  <= CLS_ALU;
      end else if (!stall_o[g]) begin
        dec_vld_q[g]  <= gnt_vld;
        dec_lidx_q[g] <= gnt_idx;
        dec_cls_q[g]  <= cls_e'(gnt_cls[1:0]);
      end
    end
  end

  dgp_resolver u_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dec_vld_i (dec_vld_q),
    .dec_cls_i (dec_cls_q),
    .issue_o   (issue_o),
    .stall_o   (stall_o)
  );
endmodule

// File: rtl/dgp_chk.sv
module dgp_chk #(
  parameter int THREADS = 8,
  parameter int CLS_W   = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [THREADS-1:0]            ready_i,
  input logic [THREADS*CLS_W-1:0]      cls_i,
  input logic [1:0]                    pick_vld_o,
  input logic [2*$clog2(THREADS)-1:0]  pick_tid_o,
  input logic [2*$clog2(THREADS)-1:0]  dec_tid_o,
  input logic [1:0]                    issue_o,
  input logic [1:0]                    stall_o
);
  localparam int TIDW    = $clog2(THREADS);
  localparam int PER_GRP = THREADS / 2;

  logic [1:0] last_loser_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               last_loser_q <= 2'b01;
    else if (stall_o != 2'b00) last_loser_q <= stall_o;
  end

  AST_ONE_LOSER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o != 2'b11);  // R7
  AST_WINNER_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o != 2'b00) |-> (stall_o != last_loser_q));  // R7

  for (genvar g = 0; g < 2; g++) begin : g_chk
    AST_PICK_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pick_vld_o[g] |-> ready_i[pick_tid_o[g*TIDW +: TIDW]]);  // R1
    AST_IDLE_NO_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_i[g*PER_GRP +: PER_GRP] == '0) |-> !pick_vld_o[g]);  // R4
    AST_HOLD_NO_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o[g] |-> (!pick_vld_o[g] && !issue_o[g]));  // R8
    AST_HOLD_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o[g] |=> ((issue_o[g] || stall_o[g])
                      && dec_tid_o[g*TIDW +: TIDW] == $past(dec_tid_o[g*TIDW +: TIDW])));  // R8
    AST_PICK_TO_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pick_vld_o[g] |=> ((issue_o[g] || stall_o[g])
                         && dec_tid_o[g*TIDW +: TIDW] == $past(pick_tid_o[g*TIDW +: TIDW])));  // R9
  end
endmodule

bind dual_group_picker dgp_chk #(.THREADS(THREADS), .CLS_W(CLS_W)) u_chk (.*);

// File: tb/tb_dual_group_picker.sv
`timescale 1ns/1ps
module tb_dual_group_picker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  ready_i = '0;
  logic [15:0] cls_i = '0;
  logic [1:0]  pick_vld_o;
  logic [5:0]  pick_tid_o;
  logic [5:0]  dec_tid_o;
  logic [1:0]  issue_o;
  logic [1:0]  stall_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk_i = ~clk_i;

  dual_group_picker dut (.*);

  // {ready, cls, pick_vld, pick_tid{g1,g0}, issue, stall, dec_tid{g1,g0}}
  localparam logic [41:0] VEC [16] = '{
    {8'h11, 16'h0000, 2'b11, 6'o40, 2'b00, 2'b00, 6'o00}, // R1 R5 reset order
    {8'h00, 16'h0000, 2'b00, 6'o00, 2'b11, 2'b00, 6'o40}, // R9 R4
    {8'hFF, 16'h5555, 2'b11, 6'o51, 2'b00, 2'b00, 6'o00}, // R2
    {8'hFF, 16'h5555, 2'b01, 6'o01, 2'b01, 2'b10, 6'o51}, // R6 R7 R3
    {8'hFF, 16'h5555, 2'b10, 6'o50, 2'b10, 2'b01, 6'o51}, // R7 alternates R8
    {8'hFF, 16'h0000, 2'b01, 6'o02, 2'b01, 2'b10, 6'o51}, // class captured at pick
    {8'h00, 16'h0000, 2'b00, 6'o00, 2'b11, 2'b00, 6'o52},
    {8'h83, 16'hAAAA, 2'b11, 6'o70, 2'b00, 2'b00, 6'o00}, // R2 skips idle
    {8'h00, 16'hAAAA, 2'b00, 6'o00, 2'b10, 2'b01, 6'o70}, // FPU conflict
    {8'h00, 16'h0000, 2'b00, 6'o00, 2'b01, 2'b00, 6'o00},
    {8'hFF, 16'h0000, 2'b11, 6'o63, 2'b00, 2'b00, 6'o00}, // R3 order after holds
    {8'h00, 16'h0000, 2'b00, 6'o00, 2'b11, 2'b00, 6'o63},
    {8'hFF, 16'h0000, 2'b11, 6'o41, 2'b00, 2'b00, 6'o00},
    {8'h00, 16'h5555, 2'b00, 6'o00, 2'b11, 2'b00, 6'o41},
    {8'hFF, 16'hAA55, 2'b11, 6'o52, 2'b00, 2'b00, 6'o00},
    {8'h00, 16'h0000, 2'b00, 6'o00, 2'b11, 2'b00, 6'o52}  // R6 LSU vs FPU no clash
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] rdy, input logic [15:0] cls);
    @(negedge clk_i);
    ready_i = rdy;
    cls_i   = cls;
    #1;
  endtask

  task automatic expect_ctl(input logic [1:0] iss, input logic [1:0] stl, input string req);
    check(issue_o == iss, req, issue_o, iss);
    check(stall_o == stl, req, stall_o, stl);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    step(8'h00, 16'h0000);
    // R10 reset state
    check(pick_vld_o == 2'b00, "R10", pick_vld_o, 0);
    expect_ctl(2'b00, 2'b00, "R10");

    for (int r = 0; r < 16; r++) begin
      logic [41:0] v;
      v = VEC[r];
      step(v[41:34], v[33:18]);
      check(pick_vld_o == v[17:16], "R1", pick_vld_o, v[17:16]);
      for (int g = 0; g < 2; g++) begin
        if (v[16+g])
          check(pick_tid_o[g*3 +: 3] == v[10+g*3 +: 3], "R2", pick_tid_o[g*3 +: 3], v[10+g*3 +: 3]);
        if (v[8+g] || v[6+g])
          check(dec_tid_o[g*3 +: 3] == v[g*3 +: 3], "R8", dec_tid_o[g*3 +: 3], v[g*3 +: 3]);
      end
      check(issue_o == v[9:8], "R9", issue_o, v[9:8]);
      check(stall_o == v[7:6], "R7", stall_o, v[7:6]);
    end

    // R10: conflict flips priority, then reset mid-run must restore order and priority
    step(8'h11, 16'h0101);
    step(8'h00, 16'h0000);
    expect_ctl(2'b01, 2'b10, "R7");
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(issue_o == 2'b00 && stall_o == 2'b00, "R10", {issue_o, stall_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(8'hFF, 16'h0101);
    check(pick_vld_o == 2'b11, "R10", pick_vld_o, 3);
    check(pick_tid_o == 6'o40, "R10", pick_tid_o, 6'o40);
    step(8'h00, 16'h0000);
    expect_ctl(2'b01, 2'b10, "R10");
    step(8'h00, 16'h0000);
    expect_ctl(2'b10, 2'b00, "R8");

    // R6: class 2'b11 in both groups is no conflict
    step(8'h11, 16'h0303);
    check(pick_tid_o == 6'o40, "R6", pick_tid_o, 6'o40);
    step(8'h00, 16'h0000);
    expect_ctl(2'b11, 2'b00, "R6");

    // R4: idle cycles leave order untouched; R3 t0 issued last so group 0 picks t1
    step(8'h00, 16'h0000);
    check(pick_vld_o == 2'b00, "R4", pick_vld_o, 0);
    step(8'h33, 16'h0000);
    check(pick_tid_o == 6'o51, "R3", pick_tid_o, 6'o51);

    done = 1;
    finish_run();
  end
endmodule